// File: doc/BRIEF.md
# Register Write-Protection Key Gate

This block stands between a peripheral's register bus and its bank of sensitive registers. Software opens the gate by writing two fixed key values, one after the other, to a dedicated key register. After that it may make any number of writes to the protected bank. Any other value written to the key register shuts the gate again, and the customary way to relock is to write 0xFF. The gate keeps no copy of the protected registers. It only produces the write-enable qualifiers that the register bank uses.

Each bus write is decoded once. A write to the key register steps the unlock state machine and never reaches a register bank. A write to a protected word reaches the bank only while the gate is open. A write to any other aligned word is passed through unconditionally. The default layout protects word offsets 0x00 to 0x14, which hold time, date, control, status, prescaler and wakeup reload. The key register sits at offset 0x24. The key values are 0xCA and then 0x53, and both are parameters.

Top module: `wp_key_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `gate_open` is 0. Nothing is open until the full key has been written after reset.
- R2: A key-register write whose data equals KEY_FIRST (0xCA), followed by a key-register write whose data equals KEY_SECOND (0x53), sets `gate_open` to 1 from the clock edge that takes the second write. Writes to other addresses in between do not disturb the sequence.
- R3: While `gate_open` is 1, every write to a protected word asserts `prot_we` in the same cycle as `wr_en`. Any number of consecutive protected writes pass until the gate is relocked.
- R4: While `gate_open` is 0, writes to protected words leave `prot_we` at 0 and do not change `gate_open`.
- R5: After a correct first key, a key-register write of any value other than KEY_SECOND returns the gate to locked. A following KEY_SECOND alone then does not open it.
- R6: While the gate is open, writing 0xFF, or any other value except KEY_FIRST, to the key register closes the gate from the next clock edge.
- R7: While the gate is open, writing KEY_FIRST to the key register closes the gate and counts as the first key byte. A following KEY_SECOND reopens the gate.
- R8: A write to an aligned word that is neither the key register (word offset 0x24) nor a protected word (word offsets 0x00 to 0x14 by default) asserts `free_we` in the same cycle, whatever the gate state.
- R9: A write to the key register asserts neither `prot_we` nor `free_we`.
- R10: A key value matches only when the whole `wr_data` word equals it zero-extended. For example, 0x1CA is a wrong value and relocks the gate.
- R11: Writing the keys in reverse order (KEY_SECOND, then KEY_FIRST) does not open the gate.
- R12: A write whose address has nonzero bits [1:0] matches no register. It asserts neither qualifier and does not change `gate_open`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W (8) | Byte offset of the write |
| wr_data | input | DATA_W (32) | Write data |
| prot_we | output | 1 | Write enable for the protected register bank |
| free_we | output | 1 | Write enable for unprotected registers |
| gate_open | output | 1 | High while protected writes are allowed |

## Verification
The bench builds the gate with its default parameters: an 8-bit offset space, 32-bit data, the key at 0x24 and six protected words. With these values every byte offset, aligned or not, can be swept in both the locked and the open state. Every 8-bit value can also be tried as the first key byte and, after a correct first byte, as the second. The bench derives the expected qualifiers from arithmetic on the offset and tracks the key sequence with its own model of the transition rules.

// File: rtl/wp_gate_pkg.sv
// Package: shared types for the write-protection key gate.
// Assumes: nothing; imported by the unlock state machine.
package wp_gate_pkg;

    // Unlock progress: locked, first key seen, open.
    typedef enum logic [1:0] {
        WPK_LOCKED = 2'd0,
        WPK_ARMED  = 2'd1,
        WPK_OPEN   = 2'd2
    } wpk_state_e;

endpackage

// File: rtl/wp_addr_decode.sv
// Module: wp_addr_decode
// Classifies a byte offset as key register, protected word or free word.
// Assumes word-aligned registers. A misaligned offset matches nothing.
// If the key word also appears in PROT_MASK, the key register wins.
module wp_addr_decode #(
    parameter int                       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]        KEY_ADDR  = 8'h24,
    parameter logic [(1<<(ADDR_W-2))-1:0] PROT_MASK = 64'h3F
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              key_hit,
    output logic              prot_hit,
    output logic              free_hit
);
    localparam int                WORD_W   = ADDR_W - 2;
    localparam int                NWORDS   = 1 << WORD_W;
    localparam logic [WORD_W-1:0] KEY_WORD = KEY_ADDR[ADDR_W-1:2];

    logic [WORD_W-1:0] word_idx;
    logic              aligned;
    logic [NWORDS-1:0] word_sel;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    // One select line per word of the offset space.
    for (genvar i = 0; i < NWORDS; i++) begin : g_sel
        assign word_sel[i] = (word_idx == WORD_W'(i));
    end

    // Combine the selects into the three exclusive classes.
    always_comb begin
        key_hit  = aligned && (word_idx == KEY_WORD);
        prot_hit = aligned && !key_hit && |(word_sel & PROT_MASK);
        free_hit = aligned && !key_hit && !prot_hit;
    end
endmodule

// File: rtl/wp_key_fsm.sv
// Module: wp_key_fsm
// Tracks the two-value unlock sequence written to the key register.
// Assumes key_wr is high for exactly one cycle per key-register write.
// A value matches only when the whole data word equals the zero-extended key.
module wp_key_fsm
    import wp_gate_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter logic [7:0]       KEY_FIRST  = 8'hCA,
    parameter logic [7:0]       KEY_SECOND = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              open
);
    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

    wpk_state_e state_q, state_d;

    // Next-state rule for a key write; any unexpected value locks.
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                WPK_LOCKED: state_d = (key_data == K1) ? WPK_ARMED : WPK_LOCKED;
                WPK_ARMED:  state_d = (key_data == K2) ? WPK_OPEN  : WPK_LOCKED;
                WPK_OPEN:   state_d = (key_data == K1) ? WPK_ARMED : WPK_LOCKED;
                default:    state_d = WPK_LOCKED;
            endcase
        end
    end

    // State register, reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WPK_LOCKED;
        else        state_q <= state_d;
    end

    assign open = (state_q == WPK_OPEN);
endmodule

// File: rtl/wp_key_gate.sv
// Module: wp_key_gate (top)
// Gates bus writes to a protected register bank behind a two-value key.
// Assumes at most one write per cycle on a single write port. The
// protected registers themselves and all reads live outside this block.
module wp_key_gate #(
    parameter int                         ADDR_W     = 8,
    parameter int                         DATA_W     = 32,
    parameter logic [ADDR_W-1:0]          KEY_ADDR   = 8'h24,
    parameter logic [7:0]                 KEY_FIRST  = 8'hCA,
    parameter logic [7:0]                 KEY_SECOND = 8'h53,
    parameter logic [(1<<(ADDR_W-2))-1:0] PROT_MASK  = 64'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_we,
    output logic              free_we,
    output logic              gate_open
);
    logic key_hit, prot_hit, free_hit;
    logic open;

    wp_addr_decode #(
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (KEY_ADDR),
        .PROT_MASK(PROT_MASK)
    ) u_decode (
        .addr    (wr_addr),
        .key_hit (key_hit),
        .prot_hit(prot_hit),
        .free_hit(free_hit)
    );

    wp_key_fsm #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (wr_en && key_hit),
        .key_data(wr_data),
        .open    (open)
    );

    // Qualify the write strobe per decoded class and gate state.
    always_comb begin
        prot_we   = wr_en && prot_hit && open;
        free_we   = wr_en && free_hit;
        gate_open = open;
    end
endmodule

// File: rtl/wp_key_gate_chk.sv
// Module: wp_key_gate_chk
// Property checker for wp_key_gate, bound to every instance of it.
// Assumes the same parameters as the instance it is bound to.
module wp_key_gate_chk #(
    parameter int                         ADDR_W     = 8,
    parameter int                         DATA_W     = 32,
    parameter logic [ADDR_W-1:0]          KEY_ADDR   = 8'h24,
    parameter logic [7:0]                 KEY_FIRST  = 8'hCA,
    parameter logic [7:0]                 KEY_SECOND = 8'h53,
    parameter logic [(1<<(ADDR_W-2))-1:0] PROT_MASK  = 64'h3F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prot_we,
    input logic              free_we,
    input logic              gate_open
);
    logic key_wr_c, prot_wr_c;

    // Independent view of the bus write class.
    always_comb begin
        key_wr_c  = wr_en && (wr_addr == KEY_ADDR);
        prot_wr_c = wr_en && (wr_addr[1:0] == 2'b00) && (wr_addr != KEY_ADDR)
                    && PROT_MASK[wr_addr[ADDR_W-1:2]];
    end

    a_r1_reset_closed: assert property (@(posedge clk)
        !rst_n |=> !gate_open);

    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(key_wr_c && wr_data == DATA_W'(KEY_SECOND)));

    a_r3_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && prot_wr_c) |-> prot_we);

    a_r4_locked_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> !prot_we);

    a_r6_ff_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_c && wr_data == DATA_W'(8'hFF)) |=> !gate_open);

    a_r9_key_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_c |-> (!prot_we && !free_we));

    a_r12_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr_c |=> $stable(gate_open));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prot_we, free_we}));
endmodule

bind wp_key_gate wp_key_gate_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND),
    .PROT_MASK (PROT_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .prot_we  (prot_we),
    .free_we  (free_we),
    .gate_open(gate_open)
);

// File: tb/wp_key_gate_bench.sv
// Bench for wp_key_gate: sweeps offsets and key values with a reference model.
module wp_key_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        prot_we, free_we, gate_open;

    int tests = 0;
    int fails = 0;
    int mstate = 0;   // 0 locked, 1 first key seen, 2 open
    bit done = 1'b0;

    always #10 clk = ~clk;

    wp_key_gate u_wp_key_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prot_we(prot_we), .free_we(free_we),
        .gate_open(gate_open)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus write; checks qualifiers in-cycle and gate state afterwards.
    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        bit aligned, is_key, is_prot, is_free;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #2;
        aligned = (a % 4 == 0);
        is_key  = aligned && (a / 4 == 9);
        is_prot = aligned && (a / 4 <= 5);
        is_free = aligned && !is_key && !is_prot;
        chk(req, {31'd0, prot_we}, {31'd0, is_prot && mstate == 2});
        chk(req, {31'd0, free_we}, {31'd0, is_free});
        if (is_key) begin
            case (mstate)
                0: mstate = (d == 32'hCA) ? 1 : 0;
                1: mstate = (d == 32'h53) ? 2 : 0;
                default: mstate = (d == 32'hCA) ? 1 : 0;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, {31'd0, gate_open}, {31'd0, mstate == 2});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the gate closed even across a protected write.
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h08;
        #2;
        chk("R1", {31'd0, gate_open}, 32'd0);
        chk("R1", {31'd0, prot_we}, 32'd0);
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b1;
        chk("R1", {31'd0, gate_open}, 32'd0);

        // R4, R8, R12: every offset while locked.
        for (int a = 0; a < 256; a++) do_write(8'(a), 32'h0, "R4/R8/R12 locked sweep");

        // R2: key with intervening free and misaligned writes.
        do_write(8'h24, 32'hCA, "R2");
        do_write(8'h30, 32'h1, "R2");
        do_write(8'h25, 32'h0, "R12");
        do_write(8'h24, 32'h53, "R2");
        chk("R2", {31'd0, gate_open}, 32'd1);

        // R3, R8, R9, R12: every offset while open (0x24 relocks; reopen after).
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h24) do_write(8'(a), 32'hFF, "R9/R6 open sweep");
            else            do_write(8'(a), 32'h0, "R3/R8/R12 open sweep");
            if (mstate != 2) begin
                do_write(8'h24, 32'hCA, "R2");
                do_write(8'h24, 32'h53, "R2");
            end
        end

        // R3: many back-to-back protected writes stay open.
        for (int i = 0; i < 12; i++) do_write(8'((i % 6) * 4), 32'(i), "R3");

        // R6: 0xFF relocks; R4: protected write then dropped.
        do_write(8'h24, 32'hFF, "R6");
        do_write(8'h10, 32'h7, "R4");

        // R5, R10: every value as first byte, followed by the second key.
        for (int b = 0; b < 256; b++) begin
            do_write(8'h24, 32'(b), "R5/R10 first byte");
            do_write(8'h24, 32'h53, "R5/R10 first byte");
            do_write(8'h24, 32'hFF, "R6");
        end

        // R5: every value as second byte after a correct first.
        for (int b = 0; b < 256; b++) begin
            do_write(8'h24, 32'hCA, "R5 second byte");
            do_write(8'h24, 32'(b), "R5 second byte");
            do_write(8'h24, 32'h53, "R5 retry needs full key");
            do_write(8'h24, 32'hFF, "R6");
        end

        // R10: upper bits set make a wrong value.
        do_write(8'h24, 32'h1CA, "R10");
        do_write(8'h24, 32'h53, "R10");
        do_write(8'h24, 32'hCA, "R10");
        do_write(8'h24, 32'hABCD_0053, "R10");

        // R11: reversed order.
        do_write(8'h24, 32'h53, "R11");
        do_write(8'h24, 32'hCA, "R11");
        do_write(8'h00, 32'h5, "R11");

        // R7: KEY_FIRST while open closes then counts as first byte.
        do_write(8'h24, 32'h53, "R7");
        chk("R7", {31'd0, gate_open}, 32'd1);
        do_write(8'h24, 32'hCA, "R7");
        chk("R7", {31'd0, gate_open}, 32'd0);
        do_write(8'h14, 32'h9, "R7");
        do_write(8'h24, 32'h53, "R7");
        chk("R7", {31'd0, gate_open}, 32'd1);

        // R6: another wrong value while open.
        do_write(8'h24, 32'h00, "R6");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule